// File: doc/BRIEF.md
# Jump and Call Bus Sequencer

This block is a small slice of an 8-bit processor: the control and datapath needed to run three opcodes with exact bus timing. Those opcodes are an absolute jump (0x4C), a subroutine call (0x20) and a no-operation (0xEA). It drives a 16-bit address and an 8-bit write-data bus. It also drives a read-not-write strobe and a sync strobe that is high during opcode fetches. Memory sits outside the block and returns read data in the same cycle an address is presented.

The design has no operand scratch register. The jump splits its two target bytes between the ALU output latch and the input data latch. The call parks its low target byte in the stack pointer while the ALU latch carries the live stack value and decrements it. Debug taps expose the program counter, stack pointer, input data latch, ALU latch and the timing-state vector, so this internal juggling can be observed from outside.

Top module: `jmpcall_seq`

## Requirements
- R1: A synchronous reset loads the program counter from `resetPc` and the stack pointer from `resetSp`. The first cycle after reset is an opcode fetch at `resetPc`, with `sync`=1, `rnw`=1 and `tstate`=011111.
- R2: `sync` is high only in opcode-fetch cycles. Every fetch reads (`rnw`=1) at the program counter, and `pcTap` equals the fetch address.
- R3: Opcode 0xEA, and any opcode other than 0x4C or 0x20, takes two cycles. The first is the fetch. The second is a read at fetch address + 1 with `tstate`=110111. The next fetch is at fetch address + 1.
- R4: Opcode 0x4C reads the low target at fetch address + 1 (`tstate` 110111), then the high target at fetch address + 2 (`tstate` 101111). The next cycle fetches at {high, low}.
- R5: While the jump's high byte is read, `aluTap` holds the low target byte. In the following fetch, `idlTap` holds the high target byte.
- R6: Opcode 0x20 takes six bus cycles, in this order: fetch; read low operand at fetch address + 1; read at 0x0100+SP; write at 0x0100+SP; write at 0x0100+((SP-1) mod 256); read high operand at fetch address + 2. The next fetch is at {high, low}.
- R7: The call pushes the address of its high operand byte, high byte first and then low byte. `rnw` is low only in those two push cycles.
- R8: From the stack read through the high-operand read, `spTap` holds the call's low target byte. At the next fetch, `spTap` equals the starting SP minus 2 (mod 256).
- R9: The call steps `tstate` (active-low one-hot) through 011111, 110111, 111011, 111101, 111110 and 101111, then returns to 011111.
- R10: Stack accesses always fall in page 0x01 and wrap inside it. With SP=0x00, the pushes go to 0x0100 and then 0x01FF, and the final SP is 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resetPc | input | 16 | Program counter loaded at reset |
| resetSp | input | 8 | Stack pointer loaded at reset |
| dataIn | input | 8 | Read data, valid in the same cycle as `addr` |
| addr | output | 16 | Bus address |
| dataOut | output | 8 | Write data, meaningful when `rnw`=0 |
| rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| sync | output | 1 | High in opcode-fetch cycles |
| pcTap | output | 16 | Program counter register |
| spTap | output | 8 | Stack pointer register |
| idlTap | output | 8 | Input data latch |
| aluTap | output | 8 | ALU output latch |
| tstate | output | 6 | Active-low one-hot timing state |

## Verification
Each bus cycle's address, strobes and write data depend only on state registered at the previous edge. They are therefore due in the same cycle as the state that produces them. The reference model predicts them one bus cycle at a time and compares them mid-cycle. Latch contents loaded at an edge (`aluTap` low byte, `spTap` parked byte, `idlTap` high byte, final SP and PC) are checked in the first cycle after that edge, which is the next model step. Stack memory contents are checked after the run, once every push has been written on its write cycle.

// File: rtl/jmpcall_pkg.sv
package jmpcall_pkg;

  typedef enum logic [5:0] {
    ST_FETCH = 6'b011111,
    ST_OPLO  = 6'b110111,
    ST_STKRD = 6'b111011,
    ST_PUSHH = 6'b111101,
    ST_PUSHL = 6'b111110,
    ST_OPHI  = 6'b101111
  } tstate_e;

  typedef enum logic [1:0] {
    ASRC_BUS   = 2'd0,
    ASRC_SP    = 2'd1,
    ASRC_LATCH = 2'd2
  } alu_src_e;

  typedef enum logic {
    AOP_PASS = 1'b0,
    AOP_DEC  = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic     addrStack;
    logic     rnw;
    logic     sync;
    logic     pcInc;
    logic     pcLoadJmp;
    logic     pcLoadCall;
    logic     idlLoad;
    logic     aluLoad;
    alu_src_e aluSrc;
    alu_op_e  aluOp;
    logic     spFromBus;
    logic     spFromAlu;
    logic     outHigh;
  } ctrl_t;

endpackage

// File: rtl/jmpcall_alu.sv
module jmpcall_alu
  import jmpcall_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      AOP_DEC: result = opA - ONE;
      default: result = opA;
    endcase
  end
endmodule

// File: rtl/jmpcall_ctrl.sv
module jmpcall_ctrl
  import jmpcall_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] OPC_JMP = 8'h4C,
  parameter logic [DATA_W-1:0] OPC_JSR = 8'h20,
  parameter logic [DATA_W-1:0] OPC_NOP = 8'hEA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  output ctrl_t             ctrl,
  output logic [5:0]        tstate
);
  tstate_e stateQ, stateD;
  logic [DATA_W-1:0] irQ;
  logic isJmp, isJsr;

  assign isJmp = (irQ == OPC_JMP);
  assign isJsr = (irQ == OPC_JSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_FETCH;
      irQ    <= OPC_NOP;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_FETCH) irQ <= dataIn;
    end
  end

  always_comb begin
    stateD = ST_FETCH;
    unique case (stateQ)
      ST_FETCH: stateD = ST_OPLO;
      ST_OPLO:  stateD = isJsr ? ST_STKRD : (isJmp ? ST_OPHI : ST_FETCH);
      ST_STKRD: stateD = ST_PUSHH;
      ST_PUSHH: stateD = ST_PUSHL;
      ST_PUSHL: stateD = ST_OPHI;
      ST_OPHI:  stateD = ST_FETCH;
      default:  stateD = ST_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.rnw    = 1'b1;
    ctrl.aluSrc = ASRC_BUS;
    ctrl.aluOp  = AOP_PASS;
    unique case (stateQ)
      ST_FETCH: begin
        ctrl.sync    = 1'b1;
        ctrl.pcInc   = 1'b1;
        ctrl.idlLoad = 1'b1;
      end
      ST_OPLO: begin
        ctrl.idlLoad = 1'b1;
        if (isJmp) begin
          ctrl.pcInc   = 1'b1;
          ctrl.aluLoad = 1'b1;
          ctrl.aluSrc  = ASRC_BUS;
        end else if (isJsr) begin
          ctrl.pcInc     = 1'b1;
          ctrl.spFromBus = 1'b1;
          ctrl.aluLoad   = 1'b1;
          ctrl.aluSrc    = ASRC_SP;
        end
      end
      ST_STKRD: begin
        ctrl.addrStack = 1'b1;
        ctrl.idlLoad   = 1'b1;
      end
      ST_PUSHH, ST_PUSHL: begin
        ctrl.addrStack = 1'b1;
        ctrl.rnw       = 1'b0;
        ctrl.outHigh   = (stateQ == ST_PUSHH);
        ctrl.aluLoad   = 1'b1;
        ctrl.aluSrc    = ASRC_LATCH;
        ctrl.aluOp     = AOP_DEC;
      end
      ST_OPHI: begin
        ctrl.idlLoad    = 1'b1;
        ctrl.pcLoadJmp  = isJmp;
        ctrl.pcLoadCall = isJsr;
        ctrl.spFromAlu  = isJsr;
      end
      default: ;
    endcase
  end

  assign tstate = stateQ;

  // R2: a fetch is always a read
  p_fetch_reads_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.sync |-> ctrl.rnw);
  // R7: high push is always followed by the low push
  p_push_order_r7: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_PUSHH) |=> (stateQ == ST_PUSHL));
  // R9: exactly one active-low state bit
  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(~tstate) == 1);
  // R3: non-branching opcodes return to fetch after one extra cycle
  p_short_op_r3: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_OPLO && !isJmp && !isJsr) |=> (stateQ == ST_FETCH));
endmodule

// File: rtl/jmpcall_dp.sv
module jmpcall_dp
  import jmpcall_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] resetPc,
  input  logic [DATA_W-1:0] resetSp,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] pcTap,
  output logic [DATA_W-1:0] spTap,
  output logic [DATA_W-1:0] idlTap,
  output logic [DATA_W-1:0] aluTap
);
  localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] spQ, idlQ, aluQ;
  logic [DATA_W-1:0] aluA, aluR;

  always_comb begin
    unique case (ctrl.aluSrc)
      ASRC_SP:    aluA = spQ;
      ASRC_LATCH: aluA = aluQ;
      default:    aluA = dataIn;
    endcase
  end

  jmpcall_alu #(.DATA_W(DATA_W)) u_alu (
    .opA   (aluA),
    .op    (ctrl.aluOp),
    .result(aluR)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= resetPc;
      spQ  <= resetSp;
      idlQ <= '0;
      aluQ <= '0;
    end else begin
      if (ctrl.pcLoadJmp)       pcQ <= {dataIn, aluQ};
      else if (ctrl.pcLoadCall) pcQ <= {dataIn, spQ};
      else if (ctrl.pcInc)      pcQ <= pcQ + PC_ONE;
      if (ctrl.spFromBus)       spQ <= dataIn;
      else if (ctrl.spFromAlu)  spQ <= aluQ;
      if (ctrl.idlLoad)         idlQ <= dataIn;
      if (ctrl.aluLoad)         aluQ <= aluR;
    end
  end

  assign addr    = ctrl.addrStack ? {STACK_PAGE, aluQ} : pcQ;
  assign dataOut = ctrl.rnw ? '0 : (ctrl.outHigh ? pcQ[ADDR_W-1:DATA_W] : pcQ[DATA_W-1:0]);
  assign pcTap   = pcQ;
  assign spTap   = spQ;
  assign idlTap  = idlQ;
  assign aluTap  = aluQ;

  // R10: writes only ever land in the stack page
  p_stack_page_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rnw |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE));
  // R7: the second push goes one below the first, inside the page
  p_push_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.rnw && $past(!ctrl.rnw)) |->
      (addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]) - 1'b1));
  // R8: parked target byte is not disturbed by the pushes
  p_sp_parked_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rnw |-> $stable(spQ));
  // R7: pushes emit the program counter, which holds still during them
  p_pc_held_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.rnw && $past(!ctrl.rnw)) |-> $stable(pcQ));
endmodule

// File: rtl/jmpcall_seq.sv
module jmpcall_seq
  import jmpcall_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] OPC_JMP    = 8'h4C,
  parameter logic [DATA_W-1:0] OPC_JSR    = 8'h20,
  parameter logic [DATA_W-1:0] OPC_NOP    = 8'hEA,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] resetPc,
  input  logic [DATA_W-1:0] resetSp,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              rnw,
  output logic              sync,
  output logic [ADDR_W-1:0] pcTap,
  output logic [DATA_W-1:0] spTap,
  output logic [DATA_W-1:0] idlTap,
  output logic [DATA_W-1:0] aluTap,
  output logic [5:0]        tstate
);
  ctrl_t ctrl;

  jmpcall_ctrl #(
    .DATA_W (DATA_W),
    .OPC_JMP(OPC_JMP),
    .OPC_JSR(OPC_JSR),
    .OPC_NOP(OPC_NOP)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .dataIn(dataIn),
    .ctrl  (ctrl),
    .tstate(tstate)
  );

  jmpcall_dp #(
    .DATA_W    (DATA_W),
    .STACK_PAGE(STACK_PAGE)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .resetPc(resetPc),
    .resetSp(resetSp),
    .dataIn (dataIn),
    .addr   (addr),
    .dataOut(dataOut),
    .pcTap  (pcTap),
    .spTap  (spTap),
    .idlTap (idlTap),
    .aluTap (aluTap)
  );

  assign rnw  = ctrl.rnw;
  assign sync = ctrl.sync;
endmodule

// File: tb/jmpcall_seq_test.sv
module jmpcall_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] resetPc = 16'h0001;
  logic [7:0]  resetSp = 8'hFD;
  logic [7:0]  dataIn;
  logic [15:0] addr, pcTap;
  logic [7:0]  dataOut, spTap, idlTap, aluTap;
  logic        rnw, sync;
  logic [5:0]  tstate;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit running  = 1'b0;

  logic [7:0] mem [int];

  function automatic logic [7:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always #4 clk = ~clk;

  assign dataIn = rd(int'(addr));

  jmpcall_seq uut (
    .clk(clk), .rst(rst), .resetPc(resetPc), .resetSp(resetSp),
    .dataIn(dataIn), .addr(addr), .dataOut(dataOut), .rnw(rnw), .sync(sync),
    .pcTap(pcTap), .spTap(spTap), .idlTap(idlTap), .aluTap(aluTap), .tstate(tstate)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mPc, mSp, k, op, lo, hi, hiSeen;
  bit idlPending;
  int expA, expRnw, expSync, expTs, expD;
  string req;

  always @(negedge clk) begin
    if (rst) begin
      k = 0; mPc = int'(resetPc); mSp = int'(resetSp); idlPending = 0;
    end else if (running) begin
      if (!rnw) mem[int'(addr)] = dataOut;
      expRnw = 1; expSync = 0; expD = -1;
      case (k)
        0: begin
          req = "R2"; expA = mPc; expSync = 1; expTs = 6'b011111;
          check(pcTap == 16'(mPc), "R2", "pcTap at fetch", pcTap, mPc);
          check(spTap == 8'(mSp), "R8", "spTap at fetch", spTap, mSp);
          if (idlPending) check(idlTap == 8'(hiSeen), "R5", "idl high byte", idlTap, hiSeen);
          idlPending = 0;
          op = rd(mPc); mPc = (mPc + 1) & 16'hFFFF; k = 1;
        end
        1: begin
          expA = mPc; expTs = 6'b110111;
          if (op == 8'h4C) begin req = "R4"; lo = rd(mPc); mPc = (mPc + 1) & 16'hFFFF; k = 2; end
          else if (op == 8'h20) begin req = "R6"; lo = rd(mPc); mPc = (mPc + 1) & 16'hFFFF; k = 3; end
          else begin req = "R3"; k = 0; end
        end
        2: begin
          req = "R4"; expA = mPc; expTs = 6'b101111;
          check(aluTap == 8'(lo), "R5", "alu low byte", aluTap, lo);
          hi = rd(mPc); hiSeen = hi; idlPending = 1; mPc = (hi << 8) | lo; k = 0;
        end
        3: begin
          req = "R6"; expA = 16'h0100 | mSp; expTs = 6'b111011;
          check(spTap == 8'(lo), "R8", "sp parked (stack read)", spTap, lo);
          k = 4;
        end
        4: begin
          req = "R7"; expA = 16'h0100 | mSp; expRnw = 0; expD = (mPc >> 8) & 8'hFF;
          expTs = 6'b111101;
          check(spTap == 8'(lo), "R8", "sp parked (push high)", spTap, lo);
          k = 5;
        end
        5: begin
          req = "R10"; expA = 16'h0100 | ((mSp - 1) & 8'hFF); expRnw = 0;
          expD = mPc & 8'hFF; expTs = 6'b111110;
          k = 6;
        end
        default: begin
          req = "R9"; expA = mPc; expTs = 6'b101111;
          check(spTap == 8'(lo), "R8", "sp parked (high operand)", spTap, lo);
          hi = rd(mPc); hiSeen = hi; idlPending = 1;
          mPc = (hi << 8) | lo; mSp = (mSp - 2) & 8'hFF; k = 0;
        end
      endcase
      check(addr == 16'(expA), req, "addr", addr, expA);
      check(rnw == 1'(expRnw), "R7", "rnw", rnw, expRnw);
      check(sync == 1'(expSync), "R2", "sync", sync, expSync);
      check(tstate == 6'(expTs), "R9", "tstate", tstate, expTs);
      if (expD >= 0) check(dataOut == 8'(expD), "R7", "push data", dataOut, expD);
    end
  end

  initial begin
    // program 1: call, no-op, jump, call, other opcode, jump loop
    mem[16'h0001] = 8'h20; mem[16'h0002] = 8'h72; mem[16'h0003] = 8'h5F;
    mem[16'h5F72] = 8'hEA;
    mem[16'h5F73] = 8'h4C; mem[16'h5F74] = 8'h00; mem[16'h5F75] = 8'h30;
    mem[16'h3000] = 8'h20; mem[16'h3001] = 8'h10; mem[16'h3002] = 8'h20;
    mem[16'h2010] = 8'h42;
    mem[16'h2011] = 8'h4C; mem[16'h2012] = 8'h11; mem[16'h2013] = 8'h20;
    // program 2: call with SP at page bottom (wrap), then jump loop
    mem[16'h4000] = 8'h20; mem[16'h4001] = 8'h34; mem[16'h4002] = 8'h12;
    mem[16'h1234] = 8'h4C; mem[16'h1235] = 8'h34; mem[16'h1236] = 8'h12;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; running = 1'b1;
    #2;
    check(addr == 16'h0001 && sync && rnw, "R1", "first fetch addr", addr, 16'h0001);
    check(tstate == 6'b011111, "R1", "reset tstate", tstate, 6'b011111);
    check(spTap == 8'hFD && pcTap == 16'h0001, "R1", "reset sp", spTap, 8'hFD);
    repeat (40) @(posedge clk);
    #1;
    check(rd(16'h01FD) == 8'h00, "R7", "push hi #1", rd(16'h01FD), 8'h00);
    check(rd(16'h01FC) == 8'h03, "R7", "push lo #1", rd(16'h01FC), 8'h03);
    check(rd(16'h01FB) == 8'h30, "R7", "push hi #2", rd(16'h01FB), 8'h30);
    check(rd(16'h01FA) == 8'h02, "R7", "push lo #2", rd(16'h01FA), 8'h02);

    // R10: second reset with SP at 0x00
    rst = 1'b1; resetPc = 16'h4000; resetSp = 8'h00;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    check(addr == 16'h4000 && sync, "R1", "fetch after reset 2", addr, 16'h4000);
    repeat (20) @(posedge clk);
    #1;
    check(rd(16'h0100) == 8'h40, "R10", "push hi wrap", rd(16'h0100), 8'h40);
    check(rd(16'h01FF) == 8'h02, "R10", "push lo wrap", rd(16'h01FF), 8'h02);
    check(spTap == 8'hFE, "R10", "final sp wrap", spTap, 8'hFE);
    running = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule